// File: doc/BRIEF.md
# Per-Thread Error Flag Registers

This block keeps sticky error flags for a multithreaded core whose threads share one register port. Two kinds of fault are recorded. An opcode fault gives each thread one flag. A stack fault gives each thread two flags, and those two flags sit in separate byte lanes of the same word. The fault sources deliver single-cycle pulse vectors with one bit per thread. A flag goes high on the clock edge after its pulse and stays high until software clears it.

The register port carries a word offset, a write strobe, write data and combinational read data. An identity register reads back the number of the thread that is making the current access. A thread clears only its own flags in three steps. It reads its identity and builds a one-hot mask from it. It reads the error word and ANDs that word with the mask. It writes the result back. Writes clear the bits written as one, and bits written as zero are left as they are.

Top module: `thread_err_regs`

## Requirements
- R1: After reset every flag is zero, so the opcode-error and stack-error words both read 0.
- R2: Reading offset OFS_ID (default 0) returns the accessing thread's number on `acc_thread`, zero-extended to the data width.
- R3: A pulse on `opc_err_pulse[n]` sets bit n of the opcode-error word at offset OFS_OPC (default 1) on the next clock edge. The bit then stays set with no further pulse until it is cleared. Bits at position NTHR and above read 0.
- R4: A pulse on `stk_lo_pulse[n]` sets bit n, and a pulse on `stk_hi_pulse[n]` sets bit n+NTHR, of the stack-error word at offset OFS_STK (default 2). Bits at position 2*NTHR and above read 0.
- R5: A write to OFS_OPC or OFS_STK clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R6: When a pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Reads of any offset other than the three defined ones return 0. Writes to OFS_ID or to an undefined offset change no flag.
- R8: When thread t reads a word, ANDs it with its own mask and writes the result back, only t's flags are cleared. The mask is bit t for the opcode word, and bits t and t+NTHR for the stack word. Flags of all other threads keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_thread | input | $clog2(NTHR) | Number of the thread performing the access |
| reg_addr | input | ADDR_W | Word offset from the register base |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data (ones clear flags) |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| opc_err_pulse | input | NTHR | Opcode fault events, one per thread |
| stk_lo_pulse | input | NTHR | Lower-lane stack fault events, one per thread |
| stk_hi_pulse | input | NTHR | Upper-lane stack fault events, one per thread |

## Verification
The bench builds the block with its defaults: eight threads, a 32-bit data word and a 4-bit offset. With only sixteen offsets it can read every one of them. With only eight threads it can run every thread through the identity read and through both mask-and-write-back clears while flags are pending on every other thread. Expected words come from a bit-level model in the bench that shifts and masks the values. The sweeps include writes and pulses that land in the same cycle, and writes that carry bits above the defined lanes.

// File: rtl/thread_err_regs.sv
module thread_err_regs #(
  parameter int NTHR    = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int OFS_ID  = 0,
  parameter int OFS_OPC = 1,
  parameter int OFS_STK = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NTHR)-1:0]   acc_thread,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NTHR-1:0]           opc_err_pulse,
  input  logic [NTHR-1:0]           stk_lo_pulse,
  input  logic [NTHR-1:0]           stk_hi_pulse
);
  localparam int TID_W = $clog2(NTHR);
  localparam int STK_W = 2 * NTHR;
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_OPC = ADDR_W'(OFS_OPC);
  localparam logic [ADDR_W-1:0] A_STK = ADDR_W'(OFS_STK);

  logic [NTHR-1:0]  opc_q;
  logic [STK_W-1:0] stk_q;
  logic [STK_W-1:0] stk_set;
  logic             wr_opc, wr_stk;

  assign wr_opc  = reg_wr && (reg_addr == A_OPC);
  assign wr_stk  = reg_wr && (reg_addr == A_STK);
  assign stk_set = {stk_hi_pulse, stk_lo_pulse};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q <= '0;
      stk_q <= '0;
    end else begin
      opc_q <= (opc_q & ~(wr_opc ? reg_wdata[NTHR-1:0]  : '0)) | opc_err_pulse;
      stk_q <= (stk_q & ~(wr_stk ? reg_wdata[STK_W-1:0] : '0)) | stk_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_ID)       reg_rdata[TID_W-1:0] = acc_thread;
    else if (reg_addr == A_OPC) reg_rdata[NTHR-1:0]  = opc_q;
    else if (reg_addr == A_STK) reg_rdata[STK_W-1:0] = stk_q;
  end

  // R3, R6: a pulse always lands, even alongside a clearing write
  p_opc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|opc_err_pulse) |=> ((opc_q & $past(opc_err_pulse)) == $past(opc_err_pulse)));
  // R4
  p_stk_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|stk_set) |=> ((stk_q & $past(stk_set)) == $past(stk_set)));
  // R3, R7: without a write to the word no flag falls
  p_opc_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_opc |=> (($past(opc_q) & ~opc_q) == '0));
  p_stk_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stk |=> (($past(stk_q) & ~stk_q) == '0));
  // R5: ones written without a coincident pulse are gone
  p_opc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_opc |=> ((opc_q & $past(reg_wdata[NTHR-1:0] & ~opc_err_pulse)) == '0));
  p_stk_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stk |=> ((stk_q & $past(reg_wdata[STK_W-1:0] & ~stk_set)) == '0));
endmodule

// File: tb/test_thread_err_regs.sv
module test_thread_err_regs;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  acc_thread = 0;
  logic [3:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [N-1:0] opc_err_pulse = 0, stk_lo_pulse = 0, stk_hi_pulse = 0;

  logic [7:0]  m_opc;
  logic [15:0] m_stk;
  int checks = 0, errors = 0;

  thread_err_regs i_thread_err_regs (
    .clk(clk), .rst_n(rst_n), .acc_thread(acc_thread), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .opc_err_pulse(opc_err_pulse), .stk_lo_pulse(stk_lo_pulse), .stk_hi_pulse(stk_hi_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [2:0] t, output logic [31:0] v);
    reg_addr = a; acc_thread = t; #1; v = reg_rdata;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, 0, v);
    chk(tag, v, exp);
  endtask

  // one clock: drive in the low phase, model the edge, return in the low phase
  task automatic cyc(logic [7:0] op, logic [7:0] lo, logic [7:0] hi,
                     logic wr, logic [3:0] a, logic [31:0] d);
    logic [7:0]  n_opc;
    logic [15:0] n_stk;
    opc_err_pulse = op; stk_lo_pulse = lo; stk_hi_pulse = hi;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    n_opc = m_opc; n_stk = m_stk;
    if (wr && a == 4'd1) n_opc = n_opc & ~d[7:0];
    if (wr && a == 4'd2) n_stk = n_stk & ~d[15:0];
    n_opc = n_opc | op;
    n_stk = n_stk | {hi, lo};
    @(posedge clk);
    @(negedge clk);
    m_opc = n_opc; m_stk = n_stk;
    opc_err_pulse = 0; stk_lo_pulse = 0; stk_hi_pulse = 0; reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic check_words(string tag);
    rd_chk(tag, 4'd1, {24'h0, m_opc});
    rd_chk(tag, 4'd2, {16'h0, m_stk});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, id;
    m_opc = 0; m_stk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 opc", 4'd1, 0);
    rd_chk("R1 stk", 4'd2, 0);

    // R2 identity for every thread
    for (int t = 0; t < N; t++) begin
      rd(4'd0, 3'(t), v);
      chk("R2 id", v, 32'(t));
    end

    // R7 undefined offsets read zero
    for (int a = 3; a < 16; a++) begin
      rd(4'(a), 3'(a), v);
      chk("R7 unused read", v, 0);
    end

    // R3 set and hold, one thread at a time
    for (int t = 0; t < N; t++) begin
      cyc(8'(1 << t), 0, 0, 0, 0, 0);
      check_words("R3 set");
    end
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    rd_chk("R3 sticky", 4'd1, 32'h0000_00ff);

    // R4 lane placement
    for (int t = 0; t < N; t++) begin
      if (t % 2 == 0) cyc(0, 8'(1 << t), 0, 0, 0, 0);
      else            cyc(0, 0, 8'(1 << t), 0, 0, 0);
      check_words("R4 set");
    end
    rd_chk("R4 lanes", 4'd2, 32'h0000_aa55);
    cyc(0, 8'hff, 8'hff, 0, 0, 0);
    rd_chk("R4 full", 4'd2, 32'h0000_ffff);

    // R7 writes to identity and undefined offsets touch nothing
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a == 2) continue;
      cyc(0, 0, 0, 1, 4'(a), 32'hffff_ffff);
      check_words("R7 ignored write");
    end

    // R5 partial clears, zero bits untouched, upper bits read zero
    cyc(0, 0, 0, 1, 4'd1, 32'hffff_ff5a);
    rd_chk("R5 opc partial", 4'd1, 32'h0000_00a5);
    cyc(0, 0, 0, 1, 4'd2, 32'hffff_0ff0);
    rd_chk("R5 stk partial", 4'd2, 32'h0000_f00f);

    // R6 set beats clear in the same cycle
    cyc(8'h5a, 0, 0, 1, 4'd1, 32'h0000_00ff);
    rd_chk("R6 opc", 4'd1, 32'h0000_005a);
    cyc(0, 8'h03, 8'h80, 1, 4'd2, 32'h0000_ffff);
    rd_chk("R6 stk", 4'd2, 32'h0000_8003);

    // R8 each thread clears only its own bits via read-AND-write
    for (int t = 0; t < N; t++) begin
      cyc(8'hff, 8'hff, 8'hff, 0, 0, 0);
      rd(4'd0, 3'(t), id);
      rd(4'd1, 3'(t), v);
      cyc(0, 0, 0, 1, 4'd1, v & (32'd1 << id));
      rd_chk("R8 opc", 4'd1, 32'(8'hff & ~(8'd1 << t)));
      rd(4'd2, 3'(t), v);
      cyc(0, 0, 0, 1, 4'd2, v & ((32'd1 << id) | (32'd1 << (id + 8))));
      rd_chk("R8 stk", 4'd2, 32'(16'hffff & ~((16'd1 << t) | (16'd1 << (t + 8)))));
      check_words("R8 model");
    end

    // R1 reset again after activity
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    m_opc = 0; m_stk = 0;
    check_words("R1 re-reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule